// File: doc/BRIEF.md
# ASCII Hex Command Parser

This block sits behind a UART receiver and turns a stream of text characters into memory-mapped bus requests. The receiver hands it one byte at a time with a valid strobe. A command line begins with the letter `M`, carries exactly four hex digits of address, and may carry exactly four more hex digits of data. The line is closed by CR, by LF, or by CR followed by LF. A line with data becomes a bus write. A line without data becomes a bus read. The request comes out as a one-cycle strobe together with a 16-bit address, 16-bit write data and a write flag.

Malformed lines are dropped quietly. A wrong first character, a character that is not hex inside a field, or a wrong digit count all cause the rest of the line to be discarded up to the next end-of-line, and no request is issued. Hex letters are accepted in either case. Blank lines and the LF of a CR-LF pair are ignored when the parser is waiting for a new command.

The controller is a four-state machine:

- **ST_IDLE** waits for the preamble.
  - On `M` it takes the *start* transition to ST_ADDR.
  - On CR or LF it takes the *blank* transition and stays in ST_IDLE.
  - On any other byte it takes the *reject* transition to ST_SKIP.
- **ST_ADDR** collects address digits.
  - When the line ends with the address full, the *read* transition issues a read and returns to ST_IDLE.
  - When the line ends with the address not full, the *abort* transition returns to ST_IDLE with no request.
  - A hex digit that arrives after the address is full takes the *to-data* transition to ST_DATA.
  - A byte that is not hex takes the *reject* transition to ST_SKIP.
- **ST_DATA** collects data digits.
  - When the line ends with the data full, the *write* transition issues a write and returns to ST_IDLE.
  - When the line ends with the data not full, the *abort* transition returns to ST_IDLE with no request.
  - A byte that is not hex takes the *reject* transition to ST_SKIP.
  - A fifth data digit takes the *overflow* transition to ST_SKIP.
- **ST_SKIP** discards bytes until it sees CR or LF. That byte takes the *resync* transition to ST_IDLE.

Top module: `hexcmd_parser`

## Requirements
- R1: While `rst_n` is low, and after it is released, `req_valid` is 0 until a complete, valid command line has been received.
- R2: The sequence `M`, four hex digits and an end-of-line produces a read: `req_valid`=1 and `req_write`=0, with `req_addr` equal to the digits taken with the first digit as the most significant nibble. The request appears in the cycle after the end-of-line byte is accepted.
- R3: The sequence `M`, four address digits, four data digits and an end-of-line produces a write. `req_write`=1, `req_addr` comes from the first four digits and `req_wdata` from the last four, each most significant nibble first.
- R4: CR (0x0D), LF (0x0A) and CR followed by LF all end a command. The LF of a CR-LF pair creates no request and does not affect the command that follows.
- R5: The lowercase letters a-f are decoded to the same values as A-F.
- R6: A line whose first byte is not `M` (0x4D) produces no request. Its bytes are discarded through the next CR or LF.
- R7: A byte that is not a hex digit inside the address or data field cancels the line: no request is issued, and parsing restarts after the next CR or LF.
- R8: A line with fewer than four address digits, or with a data field of 1, 2, 3, or 5 or more digits, produces no request.
- R9: `req_valid` is high for exactly one cycle per valid command, and only in the cycle after an accepted end-of-line byte.
- R10: A byte presented with `rx_valid`=0 has no effect on parsing.
- R11: On a read request, `req_wdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_byte | input | 8 | Received character |
| rx_valid | input | 1 | `rx_byte` is valid this cycle |
| req_valid | output | 1 | One-cycle bus request strobe |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 16 | Request address |
| req_wdata | output | 16 | Write data (0 on reads) |

## Verification
The bench feeds whole text lines and compares the outputs each cycle against a model that judges every completed line as a whole.

- **Well-formed lines.** Reads and writes are sent in upper and lower case and with each of the three terminator forms. These separate correct nibble order and case folding from swapped or mis-decoded digits.
- **Malformed lines.** The set covers a wrong preamble, a repeated preamble, a letter that is not hex mid-field, and address and data fields that are short or overlong. These show whether the parser rejects a line outright or merely mis-counts digits.
- **Back-to-back traffic and idle cycles.** Lines are sent with no gap between them, and with idle cycles that carry CR or `M` on the byte lines while `rx_valid` is low. This shows whether a CR-LF pair or a byte without its valid strobe leaks into the next command.

// File: rtl/hexcmd_pkg.sv
package hexcmd_pkg;
    localparam logic [7:0] CH_PREAMBLE = 8'h4D;
    localparam logic [7:0] CH_CR       = 8'h0D;
    localparam logic [7:0] CH_LF       = 8'h0A;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_SKIP = 2'd3
    } pstate_t;
endpackage

// File: rtl/hexcmd_char_class.sv
module hexcmd_char_class
    import hexcmd_pkg::*;
(
    input  logic [7:0] ch,
    output logic       is_pre,
    output logic       is_eol,
    output logic       is_hex,
    output logic [3:0] nib
);
    always_comb begin
        is_pre = (ch == CH_PREAMBLE);
        is_eol = (ch == CH_CR) || (ch == CH_LF);
        is_hex = 1'b0;
        nib    = 4'd0;
        if (ch >= 8'h30 && ch <= 8'h39) begin
            is_hex = 1'b1;
            nib    = 4'(ch - 8'h30);
        end else if (ch >= 8'h41 && ch <= 8'h46) begin
            is_hex = 1'b1;
            nib    = 4'(ch - 8'h37);
        end else if (ch >= 8'h61 && ch <= 8'h66) begin
            is_hex = 1'b1;
            nib    = 4'(ch - 8'h57);
        end
    end
endmodule

// File: rtl/hexcmd_field_acc.sv
module hexcmd_field_acc #(
    parameter int DIGITS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic [3:0]                   nib,
    output logic [4*DIGITS-1:0]          value,
    output logic [$clog2(DIGITS+1)-1:0]  count,
    output logic                         full
);
    localparam int W  = 4 * DIGITS;
    localparam int CW = $clog2(DIGITS + 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
            count <= '0;
        end else if (clr && push) begin
            value <= W'(nib);
            count <= CW'(1);
        end else if (clr) begin
            value <= '0;
            count <= '0;
        end else if (push) begin
            value <= {value[W-5:0], nib};
            count <= count + CW'(1);
        end
    end

    assign full = (count == CW'(DIGITS));

    // R8: the digit counter never passes the field length
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DIGITS));
    // R8: the controller never pushes into a full field
    a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr) |-> !full);
endmodule

// File: rtl/hexcmd_parser.sv
module hexcmd_parser
    import hexcmd_pkg::*;
#(
    parameter int ADDR_DIGITS = 4,
    parameter int DATA_DIGITS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [7:0]               rx_byte,
    input  logic                     rx_valid,
    output logic                     req_valid,
    output logic                     req_write,
    output logic [4*ADDR_DIGITS-1:0] req_addr,
    output logic [4*DATA_DIGITS-1:0] req_wdata
);
    localparam int AW  = 4 * ADDR_DIGITS;
    localparam int DW  = 4 * DATA_DIGITS;
    localparam int ACW = $clog2(ADDR_DIGITS + 1);
    localparam int DCW = $clog2(DATA_DIGITS + 1);

    pstate_t          state, state_nxt;
    logic             c_pre, c_eol, c_hex;
    logic [3:0]       c_nib;
    logic             a_clr, a_push, a_full;
    logic             d_clr, d_push, d_full;
    logic [AW-1:0]    a_val;
    logic [DW-1:0]    d_val;
    logic [ACW-1:0]   a_cnt;
    logic [DCW-1:0]   d_cnt;
    logic             fire_rd, fire_wr;

    hexcmd_char_class u_class (
        .ch     (rx_byte),
        .is_pre (c_pre),
        .is_eol (c_eol),
        .is_hex (c_hex),
        .nib    (c_nib)
    );

    hexcmd_field_acc #(.DIGITS(ADDR_DIGITS)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (a_clr),
        .push  (a_push),
        .nib   (c_nib),
        .value (a_val),
        .count (a_cnt),
        .full  (a_full)
    );

    hexcmd_field_acc #(.DIGITS(DATA_DIGITS)) u_data (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (d_clr),
        .push  (d_push),
        .nib   (c_nib),
        .value (d_val),
        .count (d_cnt),
        .full  (d_full)
    );

    // Next-state and field control
    always_comb begin
        state_nxt = state;
        a_clr     = 1'b0;
        a_push    = 1'b0;
        d_clr     = 1'b0;
        d_push    = 1'b0;
        fire_rd   = 1'b0;
        fire_wr   = 1'b0;
        if (rx_valid) begin
            unique case (state)
                ST_IDLE: begin
                    if (c_pre) begin
                        state_nxt = ST_ADDR;
                        a_clr     = 1'b1;
                        d_clr     = 1'b1;
                    end else if (!c_eol) begin
                        state_nxt = ST_SKIP;
                    end
                end
                ST_ADDR: begin
                    if (c_eol) begin
                        state_nxt = ST_IDLE;
                        fire_rd   = a_full;
                    end else if (c_hex) begin
                        if (a_full) begin
                            state_nxt = ST_DATA;
                            d_push    = 1'b1;
                        end else begin
                            a_push = 1'b1;
                        end
                    end else begin
                        state_nxt = ST_SKIP;
                    end
                end
                ST_DATA: begin
                    if (c_eol) begin
                        state_nxt = ST_IDLE;
                        fire_wr   = d_full;
                    end else if (c_hex && !d_full) begin
                        d_push = 1'b1;
                    end else begin
                        state_nxt = ST_SKIP;
                    end
                end
                ST_SKIP: begin
                    if (c_eol) state_nxt = ST_IDLE;
                end
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_valid <= 1'b0;
            req_write <= 1'b0;
            req_addr  <= '0;
            req_wdata <= '0;
        end else begin
            req_valid <= fire_rd || fire_wr;
            if (fire_rd) begin
                req_write <= 1'b0;
                req_addr  <= a_val;
                req_wdata <= '0;
            end else if (fire_wr) begin
                req_write <= 1'b1;
                req_addr  <= a_val;
                req_wdata <= d_val;
            end
        end
    end

    // R9: the strobe lasts one cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);
    // R9: a request only follows an accepted end-of-line byte
    a_r9_after_eol: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $past(rx_valid && c_eol));
    // R11: reads carry zero write data
    a_r11_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |-> (req_wdata == '0));
    // R10: without a valid byte the state does not move
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(state));
    // R6: a line being discarded never yields a request
    a_r6_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |=> !req_valid);
    // R3: a write needs a full address field
    a_r3_write_addr_full: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> (a_cnt == ACW'(ADDR_DIGITS)));
    // R8: the data field is empty while collecting the address
    a_r8_data_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR) |-> (d_cnt == '0));
endmodule

// File: tb/hexcmd_parser_bench.sv
module hexcmd_parser_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        rx_valid = 1'b0;
    logic        req_valid, req_write;
    logic [15:0] req_addr, req_wdata;

    always #5 clk = ~clk;

    hexcmd_parser u_hexcmd_parser (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_byte   (rx_byte),
        .rx_valid  (rx_valid),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata)
    );

    int          n_checks = 0;
    int          n_fail   = 0;
    int          cyc      = 0;
    bit          chk_on   = 1'b0;
    string       tag      = "R1";
    bit          pend_v   = 1'b0;
    bit          pend_w   = 1'b0;
    logic [15:0] pend_a   = '0;
    logic [15:0] pend_d   = '0;
    logic [7:0]  line[$];

    task automatic check(input bit ok, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int hexv(input logic [7:0] c);
        if (c >= "0" && c <= "9") return int'(c) - 48;
        if (c >= "A" && c <= "F") return int'(c) - 55;
        if (c >= "a" && c <= "f") return int'(c) - 87;
        return -1;
    endfunction

    // Line-level reference: a finished line is judged as a whole
    task automatic judge_line();
        bit ok = 1'b1;
        logic [15:0] a = '0;
        logic [15:0] d = '0;
        if (!(line.size() == 5 || line.size() == 9)) ok = 1'b0;
        else if (line[0] != 8'h4D) ok = 1'b0;
        else begin
            for (int i = 1; i < line.size(); i++)
                if (hexv(line[i]) < 0) ok = 1'b0;
        end
        if (ok) begin
            for (int i = 1; i <= 4; i++) a = {a[11:0], 4'(hexv(line[i]))};
            if (line.size() == 9)
                for (int i = 5; i <= 8; i++) d = {d[11:0], 4'(hexv(line[i]))};
            pend_v = 1'b1;
            pend_w = (line.size() == 9);
            pend_a = a;
            pend_d = d;
        end
    endtask

    task automatic model_byte(input logic [7:0] b);
        if (b == 8'h0D || b == 8'h0A) begin
            if (line.size() > 0) judge_line();
            line.delete();
        end else begin
            line.push_back(b);
        end
    endtask

    task automatic idle(input int n, input logic [7:0] junk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b0;
            rx_byte  = junk;
        end
    endtask

    task automatic send_str(input string s, input int gap);
        for (int i = 0; i < s.len(); i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_byte  = s[i];
            model_byte(s[i]);
            if (gap > 0) idle(gap, (i % 2 == 0) ? 8'h0D : 8'h4D);
        end
        idle(3, 8'h0A);
    endtask

    // Per-cycle comparison, sampled after the edge settles
    always @(posedge clk) begin
        #2;
        cyc++;
        if (chk_on) begin
            check(req_valid === pend_v, "req_valid", 16'(req_valid), 16'(pend_v));
            if (pend_v && req_valid) begin
                check(req_write === pend_w, "req_write", 16'(req_write), 16'(pend_w));
                check(req_addr === pend_a, "req_addr", req_addr, pend_a);
                check(req_wdata === pend_d, "req_wdata", req_wdata, pend_d);
            end
            pend_v = 1'b0;
        end
        if (cyc > 20000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        tag = "R1";
        repeat (3) @(negedge clk);
        check(req_valid === 1'b0, "req_valid in reset", 16'(req_valid), 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_on = 1'b1;
        idle(3, 8'h4D);

        tag = "R2"; send_str("M1234\015", 0);
        tag = "R2"; send_str("M0000\012", 1);
        tag = "R3"; send_str("MBEEF5678\012", 0);
        tag = "R3"; send_str("MFFFF0001\015\012", 2);
        tag = "R4"; send_str("MABCD\015\012M0001\015", 0);
        tag = "R4"; send_str("MC0DE\015\012\012\015M9876ABCD\012", 0);
        tag = "R5"; send_str("Mabcd1f2e\015\012", 0);
        tag = "R5"; send_str("MaBcDeFfA\015", 1);
        tag = "R6"; send_str("NBEEF\015\012", 0);
        tag = "R6"; send_str("XM1234\015", 0);
        tag = "R6"; send_str("MM1234\012", 0);
        tag = "R7"; send_str("M12G4\015", 0);
        tag = "R7"; send_str("M1234 567\015\012M4321\012", 0);
        tag = "R8"; send_str("M123\015", 0);
        tag = "R8"; send_str("M\015", 0);
        tag = "R8"; send_str("M12345\012", 0);
        tag = "R8"; send_str("M1234567\015", 0);
        tag = "R8"; send_str("M123456789\015\012", 0);
        tag = "R8"; send_str("M12345678AB\015M5555\015", 0);
        tag = "R9"; send_str("M1111\015M2222\012M3333AAAA\015", 0);
        tag = "R10"; send_str("M7E7E0F0F\015", 3);
        tag = "R11"; send_str("MBEEFFFFF\015MBEEF\015", 0);

        idle(5, 8'h00);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule